// File: doc/BRIEF.md
# Dual-Tree Barrier Synchronizer

This block gives a group of processors a hardware meeting point. A processor pulses its arrival line when it reaches a barrier and then waits. When every processor has arrived, the block pulses a release line to each of them in the same cycle. Barriers are numbered in sequence, and each processor keeps a parity bit that tells whether its next barrier is an odd one or an even one.

Arrival at an odd barrier raises that processor's odd flag and lowers its even flag. Arrival at an even barrier does the opposite. A registered AND over all odd flags sets a set/reset flip-flop, and a registered AND over all even flags clears it. The flip-flop output is the shared barrier level. A waiting processor is released from an odd barrier while the level is high, and from an even barrier while it is low. The flip-flop holds its level after a fast processor has moved on and dropped its old flag. A slow processor therefore cannot miss a release, which is the failure a single AND tree suffers from.

Top module: `barrier_sync`

## Requirements
- R1: After a synchronous active-low reset, barrier_o is 0, every bit of release_o is 0, and every bit of parity_o is 0 (0 = next barrier odd, 1 = next barrier even).
- R2: No release is given until every one of the NPROC processors has recorded an arrival at the current barrier.
- R3: If the last arrival is sampled at clock edge n, release_o goes high just after edge n+2. It is still low after edges n and n+1.
- R4: Completing an odd barrier drives barrier_o from 0 to 1 at the same edge as the release.
- R5: Completing an even barrier drives barrier_o from 1 to 0 at the same edge as the release.
- R6: A release lasts exactly one cycle, and at the following edge parity_o of that processor inverts.
- R7: An arrival pulse from a processor that is already waiting is ignored. This includes an arrival in its own release cycle. Such a pulse counts toward no barrier.
- R8: While some processors are still owed the release of the previous barrier, arrivals at the next barrier do not change barrier_o.
- R9: All processors are released in the same cycle; release_o is either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | NPROC | One-cycle arrival pulse per processor |
| release_o | output | NPROC | One-cycle release pulse per processor |
| parity_o | output | NPROC | Parity of each processor's next barrier (0 odd, 1 even) |
| barrier_o | output | 1 | Shared barrier level from the set/reset flip-flop |

## Verification
The last arrival is registered into the flags at edge n. The AND result is registered at edge n+1, and the flip-flop changes at edge n+2. The level and the release therefore appear together just after edge n+2 and clear one edge later, when the parity also inverts. The reference model counts arrivals per barrier parity. When the count completes, it arms a two-edge countdown that toggles the level. The model and the design outputs are compared at every falling clock edge, so each expected value is read in the cycle after the edge that makes it. Directed sequences repeat these counts explicitly for the latency, for arrivals made in a release cycle, and for a fast processor moving ahead.

// File: rtl/barrier_sync_pkg.sv
// Package: shared types for the barrier synchronizer.
// Assumes nothing beyond standard SystemVerilog.
package barrier_sync_pkg;

    // Which barrier a processor will reach next.
    typedef enum logic {
        PH_ODD  = 1'b0,
        PH_EVEN = 1'b1
    } phase_e;

    // Returns the phase that follows the given one.
    function automatic phase_e next_phase(input phase_e ph);
        return (ph == PH_ODD) ? PH_EVEN : PH_ODD;
    endfunction

endpackage

// File: rtl/barrier_member.sv
// Module: per-processor barrier state.
// It holds the odd and even flags, a waiting bit and the processor's parity.
// Assumes the barrier level comes from the shared flip-flop and that arrivals
// are one-cycle pulses. Arrivals while waiting are dropped.
module barrier_member
    import barrier_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic barrier_lvl,
    output logic odd_flag,
    output logic even_flag,
    output logic release_p,
    output logic parity
);

    phase_e phase_q;
    logic   waiting_q;
    logic   odd_q;
    logic   even_q;
    logic   level_match;

    // The level that frees this processor depends on the barrier it waits at.
    assign level_match = (phase_q == PH_ODD) ? barrier_lvl : ~barrier_lvl;
    assign release_p   = waiting_q & level_match;
    assign odd_flag    = odd_q;
    assign even_flag   = even_q;
    assign parity      = (phase_q == PH_EVEN);

    // Records arrivals, swaps the flags and advances the parity on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_ODD;
            waiting_q <= 1'b0;
            odd_q     <= 1'b0;
            even_q    <= 1'b0;
        end else if (release_p) begin
            waiting_q <= 1'b0;
            phase_q   <= next_phase(phase_q);
        end else if (arrive && !waiting_q) begin
            waiting_q <= 1'b1;
            if (phase_q == PH_ODD) begin
                odd_q  <= 1'b1;
                even_q <= 1'b0;
            end else begin
                even_q <= 1'b1;
                odd_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/barrier_and_tree.sv
// Module: balanced AND reduction with a registered root.
// It pads the leaves up to a power of two with ones. The result lags its
// inputs by one clock.
module barrier_and_tree #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] leaf,
    output logic             all_q
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;

    logic [2*LEAVES-1:1] node;

    // Fill the leaf row, using ones beyond the live inputs.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < WIDTH) begin : g_live
            assign node[LEAVES+i] = leaf[i];
        end else begin : g_pad
            assign node[LEAVES+i] = 1'b1;
        end
    end

    // Combine pairs of children into their parent.
    for (genvar n = 1; n < LEAVES; n++) begin : g_inner
        assign node[n] = node[2*n] & node[2*n+1];
    end

    // Register the root to fix the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) all_q <= 1'b0;
        else        all_q <= node[1];
    end

endmodule

// File: rtl/barrier_srff.sv
// Module: set/reset flip-flop that holds the barrier level.
// Assumes set and clear are never active together. If they are, set wins.
module barrier_srff (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Update the level, or hold it when neither input is active.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

endmodule

// File: rtl/barrier_sync.sv
// Module: top of the barrier synchronizer.
// It has one member per processor, one AND tree for the odd flags and one for
// the even flags, and a set/reset flip-flop that makes the shared level.
// Assumes NPROC >= 1 and one-cycle arrival pulses.
module barrier_sync #(
    parameter int NPROC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] arrive_i,
    output logic [NPROC-1:0] release_o,
    output logic [NPROC-1:0] parity_o,
    output logic             barrier_o
);

    logic [NPROC-1:0] odd_flags;
    logic [NPROC-1:0] even_flags;
    logic             odd_all_q;
    logic             even_all_q;

    // One state slice per processor.
    for (genvar p = 0; p < NPROC; p++) begin : g_member
        barrier_member u_member (
            .clk        (clk),
            .rst_n      (rst_n),
            .arrive     (arrive_i[p]),
            .barrier_lvl(barrier_o),
            .odd_flag   (odd_flags[p]),
            .even_flag  (even_flags[p]),
            .release_p  (release_o[p]),
            .parity     (parity_o[p])
        );
    end

    // Reduction over the odd flags, which drives set.
    barrier_and_tree #(.WIDTH(NPROC)) u_odd_tree (
        .clk  (clk),
        .rst_n(rst_n),
        .leaf (odd_flags),
        .all_q(odd_all_q)
    );

    // Reduction over the even flags, which drives clear.
    barrier_and_tree #(.WIDTH(NPROC)) u_even_tree (
        .clk  (clk),
        .rst_n(rst_n),
        .leaf (even_flags),
        .all_q(even_all_q)
    );

    // Holds the shared barrier level.
    barrier_srff u_level (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(odd_all_q),
        .clr_i(even_all_q),
        .q    (barrier_o)
    );

endmodule

// File: rtl/barrier_sync_chk.sv
// Module: assertion checker bound to barrier_sync.
// It watches the ports and the two registered tree outputs.
module barrier_sync_chk #(
    parameter int NPROC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPROC-1:0] release_o,
    input logic [NPROC-1:0] parity_o,
    input logic             barrier_o,
    input logic             odd_all_q,
    input logic             even_all_q
);

    // R9
    release_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> (&release_o));

    // R6
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |=> (release_o == '0));

    // R6
    parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&release_o) |=> (parity_o == ~$past(parity_o)));

    // R4
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(barrier_o) |-> $past(odd_all_q));

    // R5
    level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(barrier_o) |-> $past(even_all_q));

    // R8
    tree_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(odd_all_q && even_all_q));

endmodule

bind barrier_sync barrier_sync_chk #(.NPROC(NPROC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .release_o (release_o),
    .parity_o  (parity_o),
    .barrier_o (barrier_o),
    .odd_all_q (odd_all_q),
    .even_all_q(even_all_q)
);

// File: tb/sim_barrier_sync.sv
module sim_barrier_sync;

    localparam int NP = 4;
    localparam logic [NP-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive_i = '0;
    logic [NP-1:0] release_o;
    logic [NP-1:0] parity_o;
    logic          barrier_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_wait [NP];
    bit m_par  [NP];
    int m_cnt  [2];
    bit m_bar;
    int m_timer;

    always #2.5 clk = ~clk;

    barrier_sync #(.NPROC(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .arrive_i(arrive_i),
        .release_o(release_o), .parity_o(parity_o), .barrier_o(barrier_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NP-1:0] m_release();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = m_wait[i] && (m_par[i] ? !m_bar : m_bar);
        return r;
    endfunction

    // Behavioural model: arrival counting per parity, two-edge delay to the level
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_wait[i] = 0; m_par[i] = 0; end
            m_cnt[0] = 0; m_cnt[1] = 0; m_bar = 0; m_timer = 0;
        end else begin
            logic [NP-1:0] rel;
            rel = m_release();
            if (m_timer > 0) begin
                m_timer--;
                if (m_timer == 0) m_bar = !m_bar;
            end
            for (int i = 0; i < NP; i++) begin
                if (rel[i]) begin
                    m_wait[i] = 0;
                    m_par[i]  = !m_par[i];
                end else if (!m_wait[i] && arrive_i[i]) begin
                    m_wait[i] = 1;
                    m_cnt[m_par[i]]++;
                    if (m_cnt[m_par[i]] == NP) begin
                        m_cnt[m_par[i]] = 0;
                        m_timer = 2;
                    end
                end
            end
        end
    end

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NP-1:0] mp;
            for (int i = 0; i < NP; i++) mp[i] = m_par[i];
            chk("R2/R3 release vs model", release_o, m_release());
            chk("R4/R5 barrier vs model", barrier_o, m_bar);
            chk("R6 parity vs model", parity_o, mp);
        end
    end

    task automatic pulse(input logic [NP-1:0] m);
        arrive_i = m;
        @(negedge clk);
        arrive_i = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values are checked while reset is still held
        chk("R1 barrier at reset", barrier_o, 0);
        chk("R1 release at reset", release_o, 0);
        chk("R1 parity at reset", parity_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: all processors arrive together at the first (odd) barrier
        pulse(ALL);                 // edge n has passed
        chk("R3 no release after edge n", release_o, 0);
        @(negedge clk);
        chk("R3 no release after edge n+1", release_o, 0);
        @(negedge clk);
        chk("R3 release after edge n+2", release_o, ALL);
        chk("R4 level high at odd release", barrier_o, 1);
        chk("R9 all released together", release_o, ALL);
        // R7: arrival in the release cycle is not recorded
        pulse(ALL);
        chk("R6 release lasts one cycle", release_o, 0);
        chk("R6 parity inverted", parity_o, ALL);
        repeat (5) @(negedge clk);
        chk("R7 release-cycle arrival ignored (level)", barrier_o, 1);
        chk("R7 release-cycle arrival ignored (release)", release_o, 0);

        // R8: a fast processor enters the even barrier, the level must hold
        pulse(4'b0001);
        for (int k = 0; k < 4; k++) begin
            chk("R8 level held while others lag", barrier_o, 1);
            @(negedge clk);
        end
        pulse(4'b0010);
        pulse(4'b0001);              // R7: already waiting, ignored
        pulse(4'b0100);
        repeat (3) @(negedge clk);
        chk("R2 no release with one processor missing", release_o, 0);
        chk("R2 level unchanged with one missing", barrier_o, 1);
        pulse(4'b1000);
        @(negedge clk);
        chk("R3 no even release after edge n+1", release_o, 0);
        @(negedge clk);
        chk("R5 level low at even release", barrier_o, 0);
        chk("R5 even release given", release_o, ALL);
        @(negedge clk);
        chk("R6 parity back to odd", parity_o, 0);

        // Random arrival traffic, compared against the model each cycle
        for (int c = 0; c < 2000; c++) begin
            logic [NP-1:0] m;
            for (int i = 0; i < NP; i++) m[i] = ($urandom_range(0, 3) == 0);
            arrive_i = m;
            @(negedge clk);
        end
        arrive_i = '0;
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule